// File: doc/BRIEF.md
# Two-Wire Serial Debug Port Target Engine

This block is the target-side protocol engine of a serial debug link. The link has one bidirectional data line and a clock that the host drives. The host opens each transaction with an 8-bit request header. The header selects the debug-port or access-port register space, gives the direction and a two-bit register address, and carries a parity bit. The engine checks the header's framing and parity. It then turns the line around, answers with a three-bit acknowledge, and either sends or receives a data word with an even-parity bit.

Toward the inside of the chip the engine gives a plain register-access handshake. It presents the space select and the address, and takes ready, fault and read-data indications from a register bank. A read strobe pulses when a read is accepted. A write strobe pulses, together with the write data, only when the host's data parity is correct. The engine produces a data value and an output enable for an external pad, and it releases the line in every turnaround cycle.

Top module: `twdbg_port`

## Requirements
- R1: After reset the output enable is low, and neither the read strobe nor the write strobe is asserted while the line stays at 0.
- R2: The header is sampled on rising edges in this order, with bit 0 first: bit 0 start (must be 1), bit 1 space select (1 = access port), bit 2 direction (1 = read), bit 3 address bit 0, bit 4 address bit 1, bit 5 parity, bit 6 stop (must be 0), bit 7 park (must be 1). After one turnaround cycle the target drives a 3-bit acknowledge, LSB first. OK is 3'b001, so the bit sequence on the line is 1, 0, 0.
- R3: On a read that is acknowledged OK, the target drives 32 bits of the bank's read data, LSB first, and then their even parity. The read strobe pulses exactly once.
- R4: On a write that is acknowledged OK, one turnaround cycle follows the acknowledge. The target then samples 32 data bits, LSB first, and a parity bit. The write strobe pulses with that data when the parity is even-correct.
- R5: A write whose data parity bit is wrong produces no write strobe.
- R6: When the bank is not ready, the acknowledge is WAIT, 3'b010 (line sequence 0, 1, 0). No strobe and no data phase follow.
- R7: When the bank reports a fault, the acknowledge is FAULT, 3'b100 (line sequence 0, 0, 1), whatever the ready input is. No strobe follows.
- R8: When the header parity is not the even parity of bits 1 to 4, the line stays undriven and no access takes place.
- R9: When the stop bit is 1 or the park bit is 0, the line stays undriven and no access takes place.
- R10: The output enable is low in the turnaround cycle after the header, in the cycle after the acknowledge (writes and non-OK answers), and in the cycle after read parity. Driven bits change only on falling clock edges.
- R11: During a strobe, the space select and address outputs equal the header fields, and the write data equals the word the host sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-driven link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dio_in | input | 1 | Data line value seen at the pad |
| dio_out | output | 1 | Data value the target drives |
| dio_oe | output | 1 | Pad output enable |
| bank_sel_ap | output | 1 | Register space select, 1 = access port |
| bank_addr | output | 2 | Register address from the header |
| bank_rd | output | 1 | Read strobe, one cycle |
| bank_wr | output | 1 | Write strobe, one cycle |
| bank_wdata | output | DATA_W | Write data, valid with bank_wr |
| bank_rdata | input | DATA_W | Read data for the presented address |
| bank_ready | input | 1 | Bank can accept an access |
| bank_fault | input | 1 | Bank reports an error |

## Verification
Embedded properties check on every cycle the local rules of the engine. A write strobe always comes with correct data parity, and the two strobes are never active together. A read strobe appears only with the bank ready and error-free and after a well-formed header. The acknowledge register holds exactly one set bit while it is being driven, and the line is released in both turnaround states. Other behaviour can only be shown by the bench's scenarios. These are the bit order and values seen from the host side, the WAIT and FAULT answers, the silent discard of malformed headers and bad write parity, and that driven bits hold across rising edges. The scenarios also confirm that the address and data reaching the bank match what the host sent.

// File: rtl/twdbg_pkg.sv
package twdbg_pkg;

   localparam int HDR_BITS = 8;
   localparam int ACK_BITS = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_TRN1,
      ST_ACK,
      ST_RDATA,
      ST_TRN2,
      ST_WDATA
   } phase_e;

   localparam logic [ACK_BITS-1:0] ACK_OK    = 3'b001;
   localparam logic [ACK_BITS-1:0] ACK_WAIT  = 3'b010;
   localparam logic [ACK_BITS-1:0] ACK_FAULT = 3'b100;

   typedef struct packed {
      logic       sel_ap;
      logic       rnw;
      logic [1:0] addr;
   } req_t;

endpackage

// File: rtl/twdbg_hdr_dec.sv
module twdbg_hdr_dec
   import twdbg_pkg::*;
(
   input  logic [HDR_BITS-1:0] hdr,
   output req_t                req,
   output logic                frame_ok,
   output logic                par_ok
);

   // bit positions follow the order in which the host sends them
   localparam int B_START = 0;
   localparam int B_SEL   = 1;
   localparam int B_DIR   = 2;
   localparam int B_A0    = 3;
   localparam int B_A1    = 4;
   localparam int B_PAR   = 5;
   localparam int B_STOP  = 6;
   localparam int B_PARK  = 7;

   always_comb begin
      req.sel_ap = hdr[B_SEL];
      req.rnw    = hdr[B_DIR];
      req.addr   = {hdr[B_A1], hdr[B_A0]};
      frame_ok   = hdr[B_START] & ~hdr[B_STOP] & hdr[B_PARK];
      par_ok     = (^hdr[B_A1:B_SEL]) == hdr[B_PAR];
   end

endmodule

// File: rtl/twdbg_pad_drv.sv
module twdbg_pad_drv #(
   parameter bit LAUNCH_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drv_en,
   input  logic drv_bit,
   output logic pad_out,
   output logic pad_oe
);

   generate
      if (LAUNCH_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pad_oe  <= 1'b0;
               pad_out <= 1'b0;
            end else begin
               pad_oe  <= drv_en;
               pad_out <= drv_en & drv_bit;
            end
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pad_oe  <= 1'b0;
               pad_out <= 1'b0;
            end else begin
               pad_oe  <= drv_en;
               pad_out <= drv_en & drv_bit;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/twdbg_port.sv
module twdbg_port
   import twdbg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit LAUNCH_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dio_in,
   output logic              dio_out,
   output logic              dio_oe,
   output logic              bank_sel_ap,
   output logic [1:0]        bank_addr,
   output logic              bank_rd,
   output logic              bank_wr,
   output logic [DATA_W-1:0] bank_wdata,
   input  logic [DATA_W-1:0] bank_rdata,
   input  logic              bank_ready,
   input  logic              bank_fault
);

   localparam int              CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = 1;
   localparam logic [CNT_W-1:0] CNT_HLST = HDR_BITS - 1;
   localparam logic [CNT_W-1:0] CNT_ALST = ACK_BITS - 1;
   localparam logic [CNT_W-1:0] CNT_DLST = DATA_W;

   generate
      if (DATA_W < HDR_BITS || DATA_W > 64) begin : g_bad_width
         $error("twdbg_port: DATA_W must lie in 8..64");
      end
   endgenerate

   phase_e              state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [HDR_BITS-1:0] hdr_q;
   logic [ACK_BITS-1:0] ack_q;
   logic [DATA_W:0]     dsr_q;   // data bits plus parity in the top bit

   req_t                req;
   logic                frame_ok;
   logic                par_ok;
   logic                hdr_good;
   logic [ACK_BITS-1:0] ack_sel;
   logic                drv_en;
   logic                drv_bit;

   twdbg_hdr_dec u_dec (
      .hdr      (hdr_q),
      .req      (req),
      .frame_ok (frame_ok),
      .par_ok   (par_ok)
   );

   assign hdr_good = frame_ok & par_ok;

   always_comb begin
      if (bank_fault)       ack_sel = ACK_FAULT;
      else if (!bank_ready) ack_sel = ACK_WAIT;
      else                  ack_sel = ACK_OK;
   end

   assign bank_sel_ap = req.sel_ap;
   assign bank_addr   = req.addr;
   assign bank_wdata  = dsr_q[DATA_W-1:0];
   assign bank_rd     = (state_q == ST_TRN1) & hdr_good & req.rnw & (ack_sel == ACK_OK);
   assign bank_wr     = (state_q == ST_WDATA) & (cnt_q == CNT_DLST)
                      & ((^dsr_q[DATA_W-1:0]) == dio_in);

   // sampling and sequencing on the rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         hdr_q   <= '0;
         ack_q   <= '0;
         dsr_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (dio_in) begin
                  hdr_q   <= HDR_BITS'(1);
                  cnt_q   <= CNT_ONE;
                  state_q <= ST_HDR;
               end
            end
            ST_HDR: begin
               hdr_q[cnt_q[2:0]] <= dio_in;
               cnt_q             <= cnt_q + CNT_ONE;
               if (cnt_q == CNT_HLST) state_q <= ST_TRN1;
            end
            ST_TRN1: begin
               cnt_q <= '0;
               if (hdr_good) begin
                  ack_q   <= ack_sel;
                  state_q <= ST_ACK;
                  if (bank_rd) dsr_q <= {^bank_rdata, bank_rdata};
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_ACK: begin
               if (cnt_q == CNT_ALST) begin
                  cnt_q   <= '0;
                  state_q <= (ack_q == ACK_OK && req.rnw) ? ST_RDATA : ST_TRN2;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            ST_RDATA: begin
               if (cnt_q == CNT_DLST) begin
                  cnt_q   <= '0;
                  state_q <= ST_TRN2;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            ST_TRN2: begin
               cnt_q   <= '0;
               state_q <= (ack_q == ACK_OK && !req.rnw) ? ST_WDATA : ST_IDLE;
            end
            ST_WDATA: begin
               dsr_q[cnt_q] <= dio_in;
               if (cnt_q == CNT_DLST) begin
                  cnt_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // what the pad should show in the coming half cycle
   always_comb begin
      drv_en  = (state_q == ST_ACK) | (state_q == ST_RDATA);
      drv_bit = (state_q == ST_ACK) ? ack_q[cnt_q[1:0]] : dsr_q[cnt_q];
   end

   twdbg_pad_drv #(.LAUNCH_FALL(LAUNCH_FALL)) u_pad (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_en  (drv_en),
      .drv_bit (drv_bit),
      .pad_out (dio_out),
      .pad_oe  (dio_oe)
   );

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bank_rd, bank_wr}));

   p_wr_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |-> ((^bank_wdata) == dio_in));

   p_rd_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bank_rd |-> (bank_ready && !bank_fault));

   p_rd_hdr_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_rd |-> (par_ok && frame_ok));

   p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK) |-> ($countones(ack_q) == 1));

   p_turn_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (LAUNCH_FALL && (state_q == ST_TRN1 || state_q == ST_TRN2)) |-> !dio_oe);

endmodule

// File: tb/test_twdbg_port.sv
module test_twdbg_port;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dio_in = 1'b0;
   logic          dio_out, dio_oe;
   logic          bank_sel_ap, bank_rd, bank_wr;
   logic [1:0]    bank_addr;
   logic [DW-1:0] bank_wdata, bank_rdata;
   logic          bank_ready = 1'b1;
   logic          bank_fault = 1'b0;

   int checks = 0;
   int failures = 0;
   logic s_out, s_oe;

   typedef struct {
      bit          wr;
      bit          ap;
      logic [1:0]  addr;
      logic [31:0] data;
   } acc_t;
   acc_t exp_q[$];

   always #10 clk = ~clk;

   function automatic logic [31:0] mdl(input logic ap, input logic [1:0] a);
      return 32'h1234_5678 ^ ({30'd0, a} * 32'h1111_1111) ^ (ap ? 32'hF0F0_0F0F : 32'h0);
   endfunction

   assign bank_rdata = mdl(bank_sel_ap, bank_addr);

   twdbg_port #(.DATA_W(DW)) i_twdbg_port (
      .clk(clk), .rst_n(rst_n), .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
      .bank_sel_ap(bank_sel_ap), .bank_addr(bank_addr), .bank_rd(bank_rd),
      .bank_wr(bank_wr), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
      .bank_ready(bank_ready), .bank_fault(bank_fault)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // one host cycle: drive at the falling edge, sample shortly before the rising edge
   task automatic cyc(input bit drv, input bit b);
      @(negedge clk);
      dio_in = drv ? b : 1'b0;
      #5;
      s_out = dio_out;
      s_oe  = dio_oe;
   endtask

   // monitor: compares bank strobes with scoreboard entries
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rst_n && (bank_rd || bank_wr)) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected access", {62'd0, bank_wr, bank_rd}, 64'd0);
            end else begin
               acc_t e;
               e = exp_q.pop_front();
               chk(e.wr == bank_wr && e.ap == bank_sel_ap && e.addr == bank_addr,
                   "R11 access fields", {bank_wr, bank_sel_ap, bank_addr}, {e.wr, e.ap, e.addr});
               if (e.wr) chk(bank_wdata == e.data, "R4 write data", bank_wdata, e.data);
            end
         end
      end
   end

   // flaw: 0 none, 1 header parity, 2 stop bit, 3 park bit
   task automatic txn(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd,
                      input int flaw, input bit bad_wpar, input logic [2:0] exp_ack, input string tag);
      logic [7:0]  h;
      logic [32:0] got;
      acc_t        e;
      h[0] = 1'b1; h[1] = ap; h[2] = rnw; h[3] = a[0]; h[4] = a[1];
      h[5] = (^{ap, rnw, a}) ^ (flaw == 1);
      h[6] = (flaw == 2);
      h[7] = !(flaw == 3);
      if (flaw == 0 && exp_ack == 3'b001 && (rnw || !bad_wpar)) begin
         e.wr = !rnw; e.ap = ap; e.addr = a; e.data = rnw ? mdl(ap, a) : wd;
         exp_q.push_back(e);
      end
      for (int i = 0; i < 8; i++) cyc(1'b1, h[i]);
      cyc(1'b0, 1'b0);
      chk(!s_oe, "R10 turnaround after header", s_oe, 0);
      if (flaw != 0) begin
         for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b0);
            chk(!s_oe, tag, s_oe, 0);
         end
         return;
      end
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b0);
         chk(s_oe && s_out == exp_ack[i], tag, {s_oe, s_out}, {1'b1, exp_ack[i]});
      end
      if (rnw && exp_ack == 3'b001) begin
         for (int i = 0; i < 33; i++) begin
            cyc(1'b0, 1'b0);
            got[i] = s_out;
            chk(s_oe, "R3 data enable", s_oe, 1);
            if (i == 5) begin
               @(posedge clk);
               #2;
               chk(dio_out == got[i], "R10 falling-edge launch", dio_out, got[i]);
            end
         end
         chk(got[31:0] == mdl(ap, a), "R3 read data", got[31:0], mdl(ap, a));
         chk(got[32] == ^mdl(ap, a), "R3 read parity", got[32], ^mdl(ap, a));
         cyc(1'b0, 1'b0);
         chk(!s_oe, "R10 turnaround after read", s_oe, 0);
      end else begin
         cyc(1'b0, 1'b0);
         chk(!s_oe, "R10 turnaround after ack", s_oe, 0);
         if (!rnw && exp_ack == 3'b001) begin
            for (int i = 0; i < 32; i++) cyc(1'b1, wd[i]);
            cyc(1'b1, (^wd) ^ bad_wpar);
         end
      end
      cyc(1'b0, 1'b0);
      cyc(1'b0, 1'b0);
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b0);
         chk(!s_oe && !bank_rd && !bank_wr, "R1 reset idle", {s_oe, bank_rd, bank_wr}, 0);
      end
      // R2 R3: reads acknowledged OK
      txn(1'b0, 1'b1, 2'd1, 32'h0, 0, 1'b0, 3'b001, "R2 ack OK read");
      txn(1'b1, 1'b1, 2'd3, 32'h0, 0, 1'b0, 3'b001, "R2 ack OK read ap");
      // R4 writes
      txn(1'b1, 1'b0, 2'd2, 32'hDEAD_BEEF, 0, 1'b0, 3'b001, "R4 ack OK write");
      txn(1'b0, 1'b0, 2'd0, 32'h0000_0000, 0, 1'b0, 3'b001, "R4 ack OK write zero");
      // R5 bad write parity: monitor flags any strobe
      txn(1'b0, 1'b0, 2'd3, 32'h0F0F_0001, 0, 1'b1, 3'b001, "R5 ack before bad parity");
      // R6 bank not ready
      bank_ready = 1'b0;
      txn(1'b0, 1'b1, 2'd2, 32'h0, 0, 1'b0, 3'b010, "R6 WAIT read");
      txn(1'b1, 1'b0, 2'd1, 32'h5555_AAAA, 0, 1'b0, 3'b010, "R6 WAIT write");
      // R7 fault wins over not ready and over ready
      bank_fault = 1'b1;
      txn(1'b1, 1'b1, 2'd0, 32'h0, 0, 1'b0, 3'b100, "R7 FAULT read");
      bank_ready = 1'b1;
      txn(1'b0, 1'b0, 2'd2, 32'h1234_0000, 0, 1'b0, 3'b100, "R7 FAULT write");
      bank_fault = 1'b0;
      // R8 header parity error, R9 framing errors
      txn(1'b0, 1'b1, 2'd1, 32'h0, 1, 1'b0, 3'b001, "R8 no drive on header parity");
      txn(1'b1, 1'b0, 2'd2, 32'h0, 2, 1'b0, 3'b001, "R9 no drive on stop bit");
      txn(1'b0, 1'b1, 2'd3, 32'h0, 3, 1'b0, 3'b001, "R9 no drive on park bit");
      // recovery after discarded headers
      txn(1'b1, 1'b1, 2'd2, 32'h0, 0, 1'b0, 3'b001, "R2 ack OK after discard");
      txn(1'b1, 1'b0, 2'd3, 32'h8000_0001, 0, 1'b0, 3'b001, "R4 ack OK final write");
      repeat (3) cyc(1'b0, 1'b0);
      chk(exp_q.size() == 0, "R11 all expected accesses seen", exp_q.size(), 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule